// File: doc/BRIEF.md
# Bus Device Address Recognizer

This block decides, for one instrument sitting on a shared parallel IEEE-488 style bus, whether the bytes on the bus are meant for it. A five-bit device address is set on switches. Those switch levels reach the block through an inverting buffer, and the block re-inverts them so the local processor reads the true address. The processor then writes an address into an internal register. Until the next reset, that register alone decides which command bytes this instrument answers.

While attention is asserted, bytes are commands. The listen group code plus the device address makes the instrument a listener, and the talk group code plus the address makes it a talker. Two fixed codes drop the listener or the talker role. While attention is low, a byte is data. It is accepted only while the instrument is listening. A remote/local state is kept and can be read, but no bus byte can change it. The front panel buttons change it, and so does the first listen addressing that arrives after reset. The processor interrupt asserts only when a received byte waits to be fetched, or when the instrument is a talker with an empty transmit holding register.

Top module: `bus_addr_recognizer`

## Requirements
- R1: A synchronous reset (rst high) clears the address register and its valid flag, the listen and talk flags, the remote state, the first-command memory, both byte-holding flags and the interrupt.
- R2: sw_addr_o is the bitwise inverse of sw_n_i, so it shows the true switch address (closed switch = 1). sw_invalid_o is high exactly when that value is 31.
- R3: A pulse on addr_wr_i loads addr_wdata_i into the address register. addr_valid_o is high when the loaded value is 0 to 30. The register keeps its value through switch changes until the next write or reset.
- R4: While addr_valid_o is low (after reset, or after 31 is written), no byte sets listen_o or talk_o.
- R5: A command byte (bus_atn_i high) with upper bits 3'b001 and lower five bits equal to the address sets listen_o. Byte 8'h3F clears listen_o. A listen byte carrying another address changes nothing.
- R6: A command byte with upper bits 3'b010 and the lower five bits equal to the address sets talk_o and clears listen_o. Byte 8'h5F clears talk_o. Talk addressing works while remote_o is low and leaves remote_o unchanged.
- R7: remote_btn_i sets remote_o and local_btn_i clears it; if both are pressed together, the remote button wins. No bus byte, command or data, ever clears remote_o.
- R8: The first listen addressing of this device after reset sets remote_o. Later listen addressings leave remote_o unchanged, even after a return to local.
- R9: A data byte (bus_atn_i low) is captured into rx_data_o and raises rx_full_o only while listen_o is high. Otherwise it is ignored, and a data byte never acts as a command.
- R10: irq_o is high exactly when rx_full_o is high, or when talk_o is high and tx_full_o is low. rx_rd_i clears rx_full_o. tx_wr_i loads tx_data_o and sets tx_full_o. bus_tx_take_i clears tx_full_o while talking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_n_i | input | 5 | Switch levels after the inverting buffer |
| addr_wr_i | input | 1 | Processor write strobe for the address register |
| addr_wdata_i | input | 5 | Address written by the processor |
| sw_addr_o | output | 5 | Re-inverted true switch address |
| sw_invalid_o | output | 1 | Switch address is the refused value 31 |
| addr_o | output | 5 | Address register contents |
| addr_valid_o | output | 1 | Address register holds a usable address |
| bus_valid_i | input | 1 | One-cycle strobe: a bus byte is present |
| bus_atn_i | input | 1 | Attention: the byte is a command |
| bus_data_i | input | 8 | Bus byte |
| remote_btn_i | input | 1 | Front panel remote button |
| local_btn_i | input | 1 | Front panel local button |
| rx_rd_i | input | 1 | Processor fetches the received byte |
| rx_data_o | output | 8 | Received data byte |
| rx_full_o | output | 1 | Received byte waiting |
| tx_wr_i | input | 1 | Processor writes a byte to send |
| tx_data_i | input | 8 | Byte to send |
| tx_data_o | output | 8 | Byte held for the bus |
| tx_full_o | output | 1 | Transmit holding register occupied |
| bus_tx_take_i | input | 1 | Bus has taken the held byte |
| listen_o | output | 1 | Addressed as listener |
| talk_o | output | 1 | Addressed as talker |
| remote_o | output | 1 | Remote state status bit |
| irq_o | output | 1 | Processor interrupt |

## Verification
The assertions take as given that every bus byte is a strobe lasting one cycle, and that a talk addressing and a listen addressing never fall in the same byte. Both follow from the decode. They also take as given that the address register changes only on a write strobe. The stimulus changes inputs only on the falling clock edge. It holds each strobe for exactly one cycle, and it checks that the address is held only across cycles with no write pending. Button presses and processor accesses are kept apart from bus bytes, so each registered result can be traced back to one cause.

// File: rtl/bar_pkg.sv
package bar_pkg;
    parameter int unsigned ADDR_W = 5;
    parameter int unsigned DATA_W = 8;
    localparam int unsigned GRP_W = DATA_W - ADDR_W;
    localparam logic [GRP_W-1:0] LISTEN_GRP = GRP_W'(1);
    localparam logic [GRP_W-1:0] TALK_GRP = GRP_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_NONE = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } addr_st_t;

    typedef struct packed {
        logic listen;
        logic talk;
        logic remote;
        logic first_done;
    } role_st_t;

    typedef struct packed {
        logic [DATA_W-1:0] rx_data;
        logic              rx_full;
        logic [DATA_W-1:0] tx_data;
        logic              tx_full;
    } xfer_st_t;
endpackage

// File: rtl/bar_addr_reg.sv
module bar_addr_reg
    import bar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sw_n_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    output logic [ADDR_W-1:0] sw_addr_o,
    output logic              sw_invalid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o
);
    addr_st_t st_d, st_q;

    // undo the inverting buffer one switch at a time
    for (genvar b = 0; b < ADDR_W; b++) begin : g_reinv
        assign sw_addr_o[b] = ~sw_n_i[b];
    end

    assign sw_invalid_o = (sw_addr_o == ADDR_NONE);

    always_comb begin
        st_d = st_q;
        if (addr_wr_i) begin
            st_d.addr  = addr_wdata_i;
            st_d.valid = (addr_wdata_i != ADDR_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign addr_o       = st_q.addr;
    assign addr_valid_o = st_q.valid;

    // address register holds between writes
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !addr_wr_i |=> $stable(st_q.addr));
    // the refused value never counts as valid
    p_none_invalid_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_wr_i && addr_wdata_i == ADDR_NONE) |=> !addr_valid_o);
endmodule

// File: rtl/bar_cmd_decode.sv
module bar_cmd_decode
    import bar_pkg::*;
(
    input  logic              bus_valid_i,
    input  logic              bus_atn_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_valid_i,
    output logic              listen_hit_o,
    output logic              talk_hit_o,
    output logic              unlisten_o,
    output logic              untalk_o,
    output logic              data_strobe_o
);
    logic              cmd;
    logic [GRP_W-1:0]  grp;
    logic [ADDR_W-1:0] low;
    logic              is_none;
    logic              is_mine;

    always_comb begin
        cmd           = bus_valid_i && bus_atn_i;
        grp           = bus_data_i[DATA_W-1:ADDR_W];
        low           = bus_data_i[ADDR_W-1:0];
        is_none       = (low == ADDR_NONE);
        is_mine       = addr_valid_i && (low == addr_i);
        listen_hit_o  = cmd && (grp == LISTEN_GRP) && is_mine;
        talk_hit_o    = cmd && (grp == TALK_GRP) && is_mine;
        unlisten_o    = cmd && (grp == LISTEN_GRP) && is_none;
        untalk_o      = cmd && (grp == TALK_GRP) && is_none;
        data_strobe_o = bus_valid_i && !bus_atn_i;
    end

    always_comb begin
        a_one_role_r5: assert ($countones({listen_hit_o, talk_hit_o, unlisten_o, untalk_o}) <= 1);
    end
endmodule

// File: rtl/bar_role_ctrl.sv
module bar_role_ctrl
    import bar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_valid_i,
    input  logic listen_hit_i,
    input  logic talk_hit_i,
    input  logic unlisten_i,
    input  logic untalk_i,
    input  logic remote_btn_i,
    input  logic local_btn_i,
    output logic listen_o,
    output logic talk_o,
    output logic remote_o
);
    role_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (unlisten_i || talk_hit_i) st_d.listen = 1'b0;
        if (listen_hit_i)             st_d.listen = 1'b1;
        if (untalk_i)                 st_d.talk   = 1'b0;
        if (talk_hit_i)               st_d.talk   = 1'b1;
        if (listen_hit_i)             st_d.first_done = 1'b1;
        if (remote_btn_i)
            st_d.remote = 1'b1;
        else if (local_btn_i)
            st_d.remote = 1'b0;
        else if (listen_hit_i && !st_q.first_done)
            st_d.remote = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign listen_o = st_q.listen;
    assign talk_o   = st_q.talk;
    assign remote_o = st_q.remote;

    p_no_match_invalid_r4: assert property (@(posedge clk) disable iff (rst)
        !addr_valid_i |=> !(st_q.listen && !$past(st_q.listen)) && !(st_q.talk && !$past(st_q.talk)));
    p_talk_drops_listen_r6: assert property (@(posedge clk) disable iff (rst)
        talk_hit_i |=> st_q.talk && !st_q.listen);
    p_bus_keeps_remote_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.remote && !local_btn_i) |=> st_q.remote);
    p_first_once_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.first_done && !st_q.remote && !remote_btn_i) |=> !st_q.remote);
endmodule

// File: rtl/bar_xfer.sv
module bar_xfer
    import bar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_strobe_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              listen_i,
    input  logic              talk_i,
    input  logic              rx_rd_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              bus_tx_take_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_full_o,
    output logic              irq_o
);
    xfer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_strobe_i && listen_i) begin
            st_d.rx_data = bus_data_i;
            st_d.rx_full = 1'b1;
        end else if (rx_rd_i) begin
            st_d.rx_full = 1'b0;
        end
        if (tx_wr_i) begin
            st_d.tx_data = tx_data_i;
            st_d.tx_full = 1'b1;
        end else if (bus_tx_take_i && talk_i && st_q.tx_full) begin
            st_d.tx_full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rx_data_o = st_q.rx_data;
    assign rx_full_o = st_q.rx_full;
    assign tx_data_o = st_q.tx_data;
    assign tx_full_o = st_q.tx_full;
    assign irq_o     = st_q.rx_full || (talk_i && !st_q.tx_full);

    p_rx_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (!listen_i && !st_q.rx_full) |=> !st_q.rx_full);
    p_tx_fill_r10: assert property (@(posedge clk) disable iff (rst)
        tx_wr_i |=> st_q.tx_full && !(talk_i && !st_q.rx_full && irq_o));
    p_rx_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_rd_i && !data_strobe_i) |=> !st_q.rx_full);
endmodule

// File: rtl/bus_addr_recognizer.sv
module bus_addr_recognizer
    import bar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sw_n_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    output logic [ADDR_W-1:0] sw_addr_o,
    output logic              sw_invalid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    input  logic              bus_valid_i,
    input  logic              bus_atn_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              remote_btn_i,
    input  logic              local_btn_i,
    input  logic              rx_rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_full_o,
    input  logic              bus_tx_take_i,
    output logic              listen_o,
    output logic              talk_o,
    output logic              remote_o,
    output logic              irq_o
);
    logic listen_hit, talk_hit, unlisten, untalk, data_strobe;

    bar_addr_reg u_addr (
        .clk          (clk),
        .rst          (rst),
        .sw_n_i       (sw_n_i),
        .addr_wr_i    (addr_wr_i),
        .addr_wdata_i (addr_wdata_i),
        .sw_addr_o    (sw_addr_o),
        .sw_invalid_o (sw_invalid_o),
        .addr_o       (addr_o),
        .addr_valid_o (addr_valid_o)
    );

    bar_cmd_decode u_dec (
        .bus_valid_i   (bus_valid_i),
        .bus_atn_i     (bus_atn_i),
        .bus_data_i    (bus_data_i),
        .addr_i        (addr_o),
        .addr_valid_i  (addr_valid_o),
        .listen_hit_o  (listen_hit),
        .talk_hit_o    (talk_hit),
        .unlisten_o    (unlisten),
        .untalk_o      (untalk),
        .data_strobe_o (data_strobe)
    );

    bar_role_ctrl u_role (
        .clk          (clk),
        .rst          (rst),
        .addr_valid_i (addr_valid_o),
        .listen_hit_i (listen_hit),
        .talk_hit_i   (talk_hit),
        .unlisten_i   (unlisten),
        .untalk_i     (untalk),
        .remote_btn_i (remote_btn_i),
        .local_btn_i  (local_btn_i),
        .listen_o     (listen_o),
        .talk_o       (talk_o),
        .remote_o     (remote_o)
    );

    bar_xfer u_xfer (
        .clk           (clk),
        .rst           (rst),
        .data_strobe_i (data_strobe),
        .bus_data_i    (bus_data_i),
        .listen_i      (listen_o),
        .talk_i        (talk_o),
        .rx_rd_i       (rx_rd_i),
        .tx_wr_i       (tx_wr_i),
        .tx_data_i     (tx_data_i),
        .bus_tx_take_i (bus_tx_take_i),
        .rx_data_o     (rx_data_o),
        .rx_full_o     (rx_full_o),
        .tx_data_o     (tx_data_o),
        .tx_full_o     (tx_full_o),
        .irq_o         (irq_o)
    );

    p_data_not_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_i && !bus_atn_i && !remote_btn_i && !local_btn_i) |=>
            $stable(talk_o) && $stable(remote_o) && (listen_o == $past(listen_o)));
endmodule

// File: tb/bus_addr_recognizer_tb_top.sv
module bus_addr_recognizer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] sw_n_i = 5'h1F;
    logic       addr_wr_i = 1'b0;
    logic [4:0] addr_wdata_i = '0;
    logic [4:0] sw_addr_o;
    logic       sw_invalid_o;
    logic [4:0] addr_o;
    logic       addr_valid_o;
    logic       bus_valid_i = 1'b0;
    logic       bus_atn_i = 1'b0;
    logic [7:0] bus_data_i = '0;
    logic       remote_btn_i = 1'b0;
    logic       local_btn_i = 1'b0;
    logic       rx_rd_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_full_o;
    logic       tx_wr_i = 1'b0;
    logic [7:0] tx_data_i = '0;
    logic [7:0] tx_data_o;
    logic       tx_full_o;
    logic       bus_tx_take_i = 1'b0;
    logic       listen_o, talk_o, remote_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_addr_recognizer dut_i (
        .clk(clk), .rst(rst), .sw_n_i(sw_n_i), .addr_wr_i(addr_wr_i),
        .addr_wdata_i(addr_wdata_i), .sw_addr_o(sw_addr_o), .sw_invalid_o(sw_invalid_o),
        .addr_o(addr_o), .addr_valid_o(addr_valid_o), .bus_valid_i(bus_valid_i),
        .bus_atn_i(bus_atn_i), .bus_data_i(bus_data_i), .remote_btn_i(remote_btn_i),
        .local_btn_i(local_btn_i), .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o),
        .rx_full_o(rx_full_o), .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i),
        .tx_data_o(tx_data_o), .tx_full_o(tx_full_o), .bus_tx_take_i(bus_tx_take_i),
        .listen_o(listen_o), .talk_o(talk_o), .remote_o(remote_o), .irq_o(irq_o)
    );

    // row: [12] atn, [11:4] byte, [3] listen, [2] talk, [1] remote, [0] rx_full
    // device address 9 is loaded before the walk
    localparam int ROWS = 12;
    localparam logic [12:0] VEC [0:ROWS-1] = '{
        {1'b1, 8'h48, 4'b0000},  // talk to address 8: not ours
        {1'b1, 8'h49, 4'b0100},  // talk while local, remote stays low
        {1'b1, 8'h28, 4'b0100},  // listen to address 8: not ours
        {1'b1, 8'h29, 4'b1110},  // first listen: enters remote
        {1'b1, 8'h5F, 4'b1010},  // untalk
        {1'b1, 8'h49, 4'b0110},  // talk drops listen
        {1'b1, 8'h29, 4'b1110},  // listen again
        {1'b1, 8'h3F, 4'b0110},  // unlisten
        {1'b1, 8'h5F, 4'b0010},  // untalk, remote kept
        {1'b0, 8'h3F, 4'b0010},  // data while not listening: ignored
        {1'b1, 8'h29, 4'b1010},  // listen
        {1'b0, 8'h3F, 4'b1011}   // data looking like unlisten: captured
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic atn, input logic [7:0] b);
        bus_valid_i = 1'b1; bus_atn_i = atn; bus_data_i = b;
        tick();
        bus_valid_i = 1'b0; bus_atn_i = 1'b0;
    endtask

    task automatic write_addr(input logic [4:0] a);
        addr_wr_i = 1'b1; addr_wdata_i = a;
        tick();
        addr_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 addr_valid", addr_valid_o, 0);
        check("R1 roles", {listen_o, talk_o, remote_o}, 0);
        check("R1 buffers/irq", {rx_full_o, tx_full_o, irq_o}, 0);

        // R2 re-inversion of switch levels
        sw_n_i = ~5'd9; #1;
        check("R2 sw_addr", sw_addr_o, 9);
        check("R2 sw valid", sw_invalid_o, 0);
        sw_n_i = 5'd0; #1;
        check("R2 sw_addr all closed", sw_addr_o, 31);
        check("R2 sw invalid", sw_invalid_o, 1);

        // R4 nothing recognized before a load, nor with 31
        send(1'b1, 8'h20);
        send(1'b1, 8'h40);
        check("R4 unloaded no role", {listen_o, talk_o, remote_o}, 0);
        write_addr(5'd31);
        check("R4 31 invalid", addr_valid_o, 0);
        send(1'b1, 8'h3F);
        send(1'b1, 8'h5F);
        send(1'b1, 8'h20);
        check("R4 31 no role", {listen_o, talk_o, remote_o}, 0);

        // R3 load and hold
        sw_n_i = ~5'd9; #1;
        write_addr(sw_addr_o);
        check("R3 addr loaded", {addr_valid_o, addr_o}, {1'b1, 5'd9});
        sw_n_i = ~5'd4;
        tick(); tick();
        check("R3 addr held", addr_o, 9);

        // R5 R6 R7 R8 R9 table walk
        for (int i = 0; i < ROWS; i++) begin
            send(VEC[i][12], VEC[i][11:4]);
            check($sformatf("R5/R6/R7/R9 row %0d", i),
                  {listen_o, talk_o, remote_o, rx_full_o}, VEC[i][3:0]);
        end

        // R9 captured byte, R10 interrupt paths
        check("R9 rx_data", rx_data_o, 8'h3F);
        check("R10 irq on rx", irq_o, 1);
        rx_rd_i = 1'b1; tick(); rx_rd_i = 1'b0;
        check("R10 rx fetched", {rx_full_o, irq_o}, 0);
        send(1'b1, 8'h49);
        check("R6 talk clears listen", {listen_o, talk_o}, 2'b01);
        check("R10 irq tx need", irq_o, 1);
        tx_wr_i = 1'b1; tx_data_i = 8'hA5; tick(); tx_wr_i = 1'b0;
        check("R10 tx loaded", {tx_full_o, tx_data_o}, {1'b1, 8'hA5});
        check("R10 irq after write", irq_o, 0);
        bus_tx_take_i = 1'b1; tick(); bus_tx_take_i = 1'b0;
        check("R10 tx taken", {tx_full_o, irq_o}, 2'b01);

        // R7 R8 buttons and first-command rule
        local_btn_i = 1'b1; tick(); local_btn_i = 1'b0;
        check("R7 local button", remote_o, 0);
        send(1'b1, 8'h29);
        check("R8 later listen keeps local", {listen_o, remote_o}, 2'b10);
        remote_btn_i = 1'b1; local_btn_i = 1'b1; tick();
        remote_btn_i = 1'b0; local_btn_i = 1'b0;
        check("R7 remote button wins", remote_o, 1);

        // R1 reset mid-run, then R8 re-armed
        do_reset();
        check("R1 mid reset roles", {addr_valid_o, listen_o, talk_o, remote_o}, 0);
        check("R1 mid reset buffers", {rx_full_o, tx_full_o, irq_o}, 0);
        write_addr(5'd9);
        send(1'b1, 8'h29);
        check("R8 first listen after reset", {listen_o, remote_o}, 2'b11);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule